// File: doc/BRIEF.md
# Sequence Expander

This block takes one item at a time over a valid-ready input and turns each accepted item into a short run of output items over a valid-ready output. For an accepted value `p` and a run length of `SEQ_LEN`, the outputs are `p`, `p+1`, up to `p+SEQ_LEN-1`, in that order and modulo 2^`DATA_W`. The accepted value and a step index are kept inside the block. No new input is taken while a run is still going, except in the cycle where the last output of the run leaves.

A build-time choice, `FLOW`, decides when the first output appears. With `FLOW=1`, the first output of a run is driven combinationally from the input bus in the same cycle the input is offered. In that case the input is accepted exactly when that first output is taken. With `FLOW=0`, the item is first captured into a register and the first output appears one cycle later.

The controller has two states. `ST_IDLE` means no item is held. `ST_BUSY` means an item is held and its step index says which output is on the bus. The state changes are:
- T_CAPTURE: `ST_IDLE` to `ST_BUSY` at step 0 (`FLOW=0`).
- T_PASS: `ST_IDLE` to `ST_BUSY` at step 1, after the first output has already left combinationally (`FLOW=1`, `SEQ_LEN>1`).
- T_ADVANCE: step index plus one after a non-final output transfer.
- T_CHAIN: on the final transfer, a new item is taken and the block stays in `ST_BUSY` at step 0.
- T_FINISH: on the final transfer with no new item, back to `ST_IDLE`.
- T_HOLD: no output transfer, so nothing changes.

Top module: `seqx_top`

## Requirements
- R1: After a synchronous reset the block is in `ST_IDLE`. With `FLOW=0`, `in_ready` is 1 and `out_valid` is 0. With `FLOW=1`, `in_ready` equals `out_ready` and `out_valid` equals `in_valid`.
- R2: An accepted value `p` produces exactly `SEQ_LEN` output transfers carrying `p+k` for k = 0 .. `SEQ_LEN`-1, in increasing k. The addition wraps modulo 2^`DATA_W`.
- R3: While a held run is on a non-final step, `in_ready` is 0.
- R4: While a held run is on its final step, `in_ready` equals `out_ready`.
- R5: The step index moves only on an output transfer. While `out_valid` is 1 and `out_ready` is 0 during a held run, `out_valid` and `out_data` stay unchanged into the next cycle.
- R6: With `FLOW=1` and no held run, `out_valid` follows `in_valid` and `out_data` follows `in_data` in the same cycle, and `in_ready` equals `out_ready`.
- R7: With `FLOW=0` and no held run, `out_valid` is 0 and `in_ready` is 1. The first output of an accepted item appears on the following cycle.
- R8: An item accepted together with the final output of the previous run has its first output, step 0, on the very next cycle, with no idle cycle in between.
- R9: Asserting `rst` for one clock edge in the middle of a run drops the held item. The block returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item offered |
| in_ready | output | 1 | Block takes the offered item this cycle |
| in_data | input | DATA_W | Input item value |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_data | output | DATA_W | Output item value |

## Verification
The corner cases are these:
- Back-to-back items where the next input is taken as the last output leaves. A design that waits for `ST_IDLE` would insert a bubble. One that mishandles the chain would skip step 0 or reuse the old value.
- Long stalls of `out_ready` in the middle of a run. A design that advances the step on `out_valid` alone would lose outputs.
- Input values near the top of the range, to expose a sum that fails to wrap.
- A reset in the middle of a run. A design that does not clear the held state would keep emitting stale outputs.
- Both `FLOW` settings, each compared every cycle against a behavioural count-down model. A flow design that registers the first output shows a one-cycle lag. A non-flow design that leaks the input bus shows early valids.

// File: rtl/seqx_pkg.sv
package seqx_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seqx_state_e;
endpackage

// File: rtl/seqx_fsm.sv
module seqx_fsm
    import seqx_pkg::*;
#(
    parameter int SEQ_LEN = 3,
    parameter bit FLOW    = 1'b1,
    parameter int STEP_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              busy,
    output logic              load,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);
    localparam logic [STEP_W-1:0] PASS_STEP = STEP_W'(1);
    localparam bit SINGLE_FLOW = FLOW && (SEQ_LEN == 1);

    seqx_state_e       state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              last, accept, xfer;

    assign busy   = (state_q == ST_BUSY);
    assign step   = step_q;
    assign last   = (step_q == LAST_STEP);
    assign accept = in_valid && in_ready;
    assign xfer   = out_valid && out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Handshake outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = FLOW ? out_ready : 1'b1;
                out_valid = FLOW && in_valid;
            end
            ST_BUSY: begin
                in_ready  = out_ready && last;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        load = accept && !((state_q == ST_IDLE) && SINGLE_FLOW);
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!FLOW) begin                 // T_CAPTURE
                        state_d = ST_BUSY;
                        step_d  = '0;
                    end else if (!SINGLE_FLOW) begin // T_PASS
                        state_d = ST_BUSY;
                        step_d  = PASS_STEP;
                    end
                end
            end
            ST_BUSY: begin
                if (xfer) begin
                    if (!last) begin                 // T_ADVANCE
                        step_d = step_q + 1'b1;
                    end else if (accept) begin       // T_CHAIN
                        step_d = '0;
                    end else begin                   // T_FINISH
                        state_d = ST_IDLE;
                        step_d  = '0;
                    end
                end                                  // else T_HOLD
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    // R3: no input taken on a non-final step
    p_block_mid_r3: assert property (@(posedge clk) disable iff (rst)
        busy && !last |-> !in_ready);

    // R4: final step passes downstream readiness upstream
    p_final_ready_r4: assert property (@(posedge clk) disable iff (rst)
        busy && last |-> (in_ready == out_ready));

    // R5: a stalled held run keeps its step
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        busy && !out_ready |=> busy && $stable(step_q));

    // R5: a non-final transfer advances by exactly one
    p_advance_r5: assert property (@(posedge clk) disable iff (rst)
        busy && out_ready && !last |=> busy && (step_q == $past(step_q) + 1'b1));

    // R8: an item chained on the final step starts at step 0
    p_chain_r8: assert property (@(posedge clk) disable iff (rst)
        busy && last && out_ready && in_valid |=> busy && (step_q == '0));
endmodule

// File: rtl/seqx_gen.sv
module seqx_gen #(
    parameter int DATA_W = 8,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              busy,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= in_data;
        end
    end

    // Held run: stored value plus step, wrapping. Otherwise pass the input bus.
    always_comb begin
        if (busy) begin
            out_data = held_q + DATA_W'(step);
        end else begin
            out_data = in_data;
        end
    end

    // R2: held value does not change inside a run unless a new item is loaded
    p_item_hold_r2: assert property (@(posedge clk) disable iff (rst)
        busy && !load |=> $stable(held_q));
endmodule

// File: rtl/seqx_top.sv
module seqx_top #(
    parameter int DATA_W  = 8,
    parameter int SEQ_LEN = 3,
    parameter bit FLOW    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int STEP_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

    logic              busy;
    logic              load;
    logic [STEP_W-1:0] step;

    seqx_fsm #(
        .SEQ_LEN (SEQ_LEN),
        .FLOW    (FLOW),
        .STEP_W  (STEP_W)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .busy      (busy),
        .load      (load),
        .step      (step)
    );

    seqx_gen #(
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) gen_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .busy     (busy),
        .step     (step),
        .in_data  (in_data),
        .out_data (out_data)
    );

    // R5: a stalled output holds valid and data
    p_data_stall_r5: assert property (@(posedge clk) disable iff (rst)
        busy && !out_ready |=> out_valid && $stable(out_data));

    // R7: an accepted item shows output on the next cycle
    p_next_valid_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !(FLOW && SEQ_LEN == 1) |=> out_valid);

    // R6: flow mode presents the input bus while idle
    p_flow_pass_r6: assert property (@(posedge clk) disable iff (rst)
        FLOW && !busy |-> (out_valid == in_valid) && (out_data == in_data));
endmodule

// File: tb/seqx_top_tb_top.sv
`timescale 1ns/1ps
module seqx_top_tb_top;
    localparam int DW = 8;
    localparam int LEN0 = 3;
    localparam int LEN1 = 4;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic          iv  [2];
    logic          ir  [2];
    logic [DW-1:0] id  [2];
    logic          ov  [2];
    logic          ordy[2];
    logic [DW-1:0] od  [2];

    seqx_top #(.DATA_W(DW), .SEQ_LEN(LEN0), .FLOW(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(iv[0]), .in_ready(ir[0]), .in_data(id[0]),
        .out_valid(ov[0]), .out_ready(ordy[0]), .out_data(od[0]));

    seqx_top #(.DATA_W(DW), .SEQ_LEN(LEN1), .FLOW(1'b0)) dut_nf_i (
        .clk(clk), .rst(rst),
        .in_valid(iv[1]), .in_ready(ir[1]), .in_data(id[1]),
        .out_valid(ov[1]), .out_ready(ordy[1]), .out_data(od[1]));

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int rem [2];
    int cur [2];
    int len [2];
    bit flw [2];
    bit acc [2];
    bit xfr [2];
    int item_no [2];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_lane(input int d);
        bit eov, eir;
        int eod;
        string t;
        eov = (rem[d] > 0) || (flw[d] && iv[d]);
        eod = (rem[d] > 0) ? ((cur[d] + len[d] - rem[d]) % 256) : int'(id[d]);
        if (rem[d] == 0) eir = flw[d] ? ordy[d] : 1'b1;
        else             eir = (rem[d] == 1) && ordy[d];
        // R5 stall/hold, R6 flow pass, R7 non-flow idle
        t = (rem[d] > 0) ? "R5" : (flw[d] ? "R6" : "R7");
        check(ov[d] == eov, t, $sformatf("lane%0d out_valid", d), int'(ov[d]), int'(eov));
        if (eov) begin
            // R2 values p+k, R8 chained step 0
            t = (rem[d] > 0) ? ((rem[d] == len[d]) ? "R8" : "R2") : "R6";
            check(od[d] == DW'(eod), t, $sformatf("lane%0d out_data", d), int'(od[d]), eod);
        end
        // R3 mid-run block, R4 final step
        t = (rem[d] == 0) ? (flw[d] ? "R6" : "R7") : ((rem[d] == 1) ? "R4" : "R3");
        check(ir[d] == eir, t, $sformatf("lane%0d in_ready", d), int'(ir[d]), int'(eir));
        acc[d] = iv[d] && eir;
        xfr[d] = eov && ordy[d];
    endtask

    task automatic update_lane(input int d);
        if (rst) begin
            rem[d] = 0;
        end else if (rem[d] > 0) begin
            if (xfr[d]) rem[d] = rem[d] - 1;
            if (acc[d]) begin cur[d] = int'(id[d]); rem[d] = len[d]; end
        end else if (acc[d]) begin
            cur[d] = int'(id[d]);
            rem[d] = flw[d] ? len[d] - 1 : len[d];
        end
    endtask

    task automatic drive_lane(input int d, input int cyc);
        if (acc[d] || !iv[d]) begin
            iv[d] = ($urandom % 4) != 0;
            if (iv[d]) begin
                item_no[d]++;
                id[d] = (item_no[d] % 4 == 0) ? DW'(8'hFE + (item_no[d] % 2)) : DW'($urandom);
            end
        end
        if (cyc >= 200 && cyc < 260) ordy[d] = 1'b1;          // back-to-back chaining
        else if (cyc >= 400 && cyc < 460) ordy[d] = (cyc % 7) == 0; // long stalls
        else ordy[d] = ($urandom % 3) != 0;
        if (cyc >= 200 && cyc < 260) iv[d] = 1'b1;
    endtask

    initial begin
        len[0] = LEN0; flw[0] = 1'b1;
        len[1] = LEN1; flw[1] = 1'b0;
        for (int d = 0; d < 2; d++) begin
            rem[d] = 0; cur[d] = 0; acc[d] = 0; xfr[d] = 0; item_no[d] = 0;
            iv[d] = 1'b0; id[d] = '0; ordy[d] = 1'b1;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state of both variants
        check(ov[0] == iv[0] && ir[0] == ordy[0], "R1", "flow idle handshake", int'({ov[0], ir[0]}), int'({iv[0], ordy[0]}));
        check(ov[1] == 1'b0, "R1", "nonflow out_valid", int'(ov[1]), 0);
        check(ir[1] == 1'b1, "R1", "nonflow in_ready", int'(ir[1]), 1);

        for (int cyc = 0; cyc < 2000; cyc++) begin
            @(negedge clk);
            rst = (cyc == 900);
            for (int d = 0; d < 2; d++) drive_lane(d, cyc);
            #1;
            if (cyc == 901) begin
                // R9: mid-run reset returned the block to idle
                check(ov[1] == 1'b0, "R9", "nonflow out_valid after reset", int'(ov[1]), 0);
                check(ir[1] == 1'b1, "R9", "nonflow in_ready after reset", int'(ir[1]), 1);
                check(ov[0] == iv[0], "R9", "flow out_valid after reset", int'(ov[0]), int'(iv[0]));
            end
            for (int d = 0; d < 2; d++) compare_lane(d);
            @(posedge clk);
            for (int d = 0; d < 2; d++) update_lane(d);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule